// File: doc/BRIEF.md
# Tone-Burst Reply Receiver

The block waits for a reply on a single-wire control bus that signals with bursts of carrier tone. A digitized tone-present input comes from an analog detector outside the block. When the host reports that its own transmission has finished, the block opens a listen window. It then times each tone burst in units of a programmable ratio tick. Bursts that are too short are thrown away as glitches. Each remaining burst becomes one data bit, and the bits are collected MSB first into bytes in an eight-entry receive buffer.

The window closes after a programmable run of silent ticks. At that point the block records whether a reply arrived, whether the reply ended partway through a byte, or whether no reply came at all. Five sticky status flags record these events. Four of them can reach a single interrupt line through individual enable bits; the buffer-overflow flag never can. A software abort, or the start of a new host transmission, ends any reception in progress. The block then ignores the line until the next transmission has finished.

Software reaches the block through a small register port with write and read strobes and a 3-bit address. Reading the receive-data register removes the oldest byte from the buffer.

Top module: `tone_reply_rx`

## Requirements
- R1: After reset the registers read as follows: timing register 0xE0, divider 0, silence limit 64, interrupt enables 0, status 0, buffer count 0. The listening bit (control register bit 1) is 0 and irq_o is low.
- R2: A ratio tick occurs once every (divider + 1) clock cycles. The divider is at address 4. All burst widths and silence lengths are counted in ticks.
- R3: The timing register is at address 3. Its bits [7:5] hold a minimum-width code c, and the minimum width is (24 + c) ticks. A burst shorter than this is discarded: it yields no bit and does not count as a reply.
- R4: Timing register bits [4:2] hold an extension code e. The extension is (7 + e) ticks, and codes 5 to 7 give 11. A qualified burst whose width is at least minimum + extension decodes as 0. A shorter qualified burst decodes as 1.
- R5: Decoded bits are shifted in MSB first. Every 8th bit completes a byte. If the buffer has room, the byte is stored and status bit 0 is set.
- R6: A pulse on tx_done_i opens the listen window. While the window is closed, bursts on tone_i have no effect.
- R7: The window closes once the line has been silent for the number of ticks in the silence register (address 5; a value of 0 acts as 1). If the window received any bit, status bit 1 is set, and status bit 2 is also set when 1 to 7 bits of an unfinished byte were left over. If the window received no bit, status bit 3 is set.
- R8: Writing 1 to control register bit 0 (address 0) closes the window on the next edge and discards any unfinished byte. The line is then ignored until the next tx_done_i.
- R9: A pulse on tx_start_i has the same effect as the software abort in R8.
- R10: Status bits (address 2) are sticky. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R11: irq_o is the OR of status bits 0 to 3, each ANDed with the matching bit of the interrupt-enable register (address 1, bits [3:0]).
- R12: When a byte completes while the buffer already holds 8 bytes, the byte is dropped, the count stays at 8 and status bit 4 is set. Status bit 4 never affects irq_o.
- R13: A read strobe at address 6 returns the oldest buffered byte and removes it from the buffer. When the buffer is empty, this read returns 0. Address 7 returns the number of buffered bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tone_i | input | 1 | Digitized tone-present input |
| tx_start_i | input | 1 | Pulse: the host begins a transmission |
| tx_done_i | input | 1 | Pulse: the host transmission has ended |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops data at address 6) |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | REG_DW | Register write data |
| reg_rdata_o | output | REG_DW | Register read data, combinational on the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an eight-byte buffer and 8-bit registers and counters. With these, the overflow case is reached by sending a ninth byte in a single window. Most tests program the divider to 0, so that one tick equals one clock and burst widths can be placed a few ticks either side of each threshold. A final pass with divider 3 shows that the same tick counts also hold when the tick is scaled. The silence limit is set to 40 ticks, which is long enough to bridge the gaps between bits and short enough to close each window quickly.

// File: rtl/tone_rx_pkg.sv
package tone_rx_pkg;
  localparam logic [2:0] ADDR_CTRL    = 3'd0;
  localparam logic [2:0] ADDR_IRQ_EN  = 3'd1;
  localparam logic [2:0] ADDR_STAT    = 3'd2;
  localparam logic [2:0] ADDR_TIMING  = 3'd3;
  localparam logic [2:0] ADDR_DIV     = 3'd4;
  localparam logic [2:0] ADDR_SILENCE = 3'd5;
  localparam logic [2:0] ADDR_RXDATA  = 3'd6;
  localparam logic [2:0] ADDR_RXCNT   = 3'd7;

  localparam int unsigned NUM_FLAGS = 5;
  localparam int unsigned NUM_IRQ   = 4;
  localparam int unsigned FLG_BYTE  = 0;
  localparam int unsigned FLG_DONE  = 1;
  localparam int unsigned FLG_ERR   = 2;
  localparam int unsigned FLG_NOREP = 3;
  localparam int unsigned FLG_OVF   = 4;

  localparam int unsigned MIN_BASE     = 24;
  localparam int unsigned EXT_BASE     = 7;
  localparam int unsigned EXT_MAX_CODE = 4;
  localparam int unsigned SIL_RST      = 64;

  typedef struct packed {
    logic [2:0] min_code;
    logic [2:0] ext_code;
  } timing_t;
endpackage

// File: rtl/tone_rx_tick.sv
module tone_rx_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= keeps the divider safe when div_i is lowered mid-count
  assign tick_o = (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tone_rx_decoder.sv
module tone_rx_decoder
  import tone_rx_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tone_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              soft_rst_i,
  input  timing_t           timing_i,
  input  logic [CNT_W-1:0]  sil_lim_i,
  output logic              listen_o,
  output logic              byte_vld_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              done_o,
  output logic              err_o,
  output logic              norep_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic              tone_q, tone_d;
  logic [CNT_W-1:0]  wid_q, sil_q;
  logic [DATA_W-1:0] shf_q;
  logic [BIT_W-1:0]  nbit_q;
  logic              got_q, listen_q;

  logic [CNT_W-1:0]  min_thr, long_thr, sil_lim;
  logic [2:0]        ext_sel;
  logic              abort, fall, bit_vld, bit_val, sil_hit;

  always_comb begin
    ext_sel  = (timing_i.ext_code > 3'(EXT_MAX_CODE)) ? 3'(EXT_MAX_CODE) : timing_i.ext_code;
    min_thr  = CNT_W'(MIN_BASE) + CNT_W'(timing_i.min_code);
    long_thr = min_thr + CNT_W'(EXT_BASE) + CNT_W'(ext_sel);
    sil_lim  = (sil_lim_i == '0) ? CNT_W'(1) : sil_lim_i;
    abort    = soft_rst_i | tx_start_i;
    fall     = tone_d & ~tone_q;
    bit_vld  = listen_q && fall && (wid_q >= min_thr);
    bit_val  = (wid_q < long_thr);
    sil_hit  = listen_q && tick_i && !tone_q &&
               (({1'b0, sil_q} + 1'b1) >= {1'b0, sil_lim});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tone_q     <= 1'b0;
      tone_d     <= 1'b0;
      wid_q      <= '0;
      sil_q      <= '0;
      shf_q      <= '0;
      nbit_q     <= '0;
      got_q      <= 1'b0;
      listen_q   <= 1'b0;
      byte_vld_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      norep_o    <= 1'b0;
    end else begin
      tone_q     <= tone_i;
      tone_d     <= tone_q;
      byte_vld_o <= 1'b0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      norep_o    <= 1'b0;

      if (!tone_q)                             wid_q <= '0;
      else if (tick_i && (wid_q != CNT_MAX))   wid_q <= wid_q + 1'b1;

      if (abort) begin
        listen_q <= 1'b0;
        nbit_q   <= '0;
        got_q    <= 1'b0;
        sil_q    <= '0;
      end else if (tx_done_i) begin
        listen_q <= 1'b1;
        nbit_q   <= '0;
        got_q    <= 1'b0;
        sil_q    <= '0;
      end else if (listen_q) begin
        if (tone_q)      sil_q <= '0;
        else if (tick_i) sil_q <= sil_q + 1'b1;

        if (bit_vld) begin
          shf_q  <= {shf_q[DATA_W-2:0], bit_val};
          got_q  <= 1'b1;
          nbit_q <= nbit_q + 1'b1;
          if (nbit_q == LAST_BIT) byte_vld_o <= 1'b1;
        end

        if (sil_hit) begin
          listen_q <= 1'b0;
          nbit_q   <= '0;
          if (got_q) begin
            done_o <= 1'b1;
            err_o  <= (nbit_q != '0);
          end else begin
            norep_o <= 1'b1;
          end
        end
      end
    end
  end

  assign listen_o = listen_q;
  assign byte_o   = shf_q;
endmodule

// File: rtl/tone_rx_fifo.sv
module tone_rx_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [W-1:0]           din_i,
  input  logic                   pop_i,
  output logic [W-1:0]           dout_o,
  output logic [$clog2(DEPTH):0] cnt_o,
  output logic                   full_o,
  output logic                   empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CW    = PTR_W + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + 1'b1;
      if (do_pop)  rd_q <= rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tone_rx_regs.sv
module tone_rx_regs
  import tone_rx_pkg::*;
#(
  parameter int unsigned REG_DW = 8,
  parameter int unsigned CW     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [2:0]           addr_i,
  input  logic [REG_DW-1:0]    wdata_i,
  input  logic                 listen_i,
  input  logic [NUM_FLAGS-1:0] flag_set_i,
  input  logic [REG_DW-1:0]    fifo_dout_i,
  input  logic [CW-1:0]        fifo_cnt_i,
  input  logic                 fifo_empty_i,
  output logic [REG_DW-1:0]    rdata_o,
  output logic                 irq_o,
  output logic                 soft_rst_o,
  output logic                 pop_o,
  output timing_t              timing_o,
  output logic [REG_DW-1:0]    div_o,
  output logic [REG_DW-1:0]    sil_lim_o,
  output logic [NUM_IRQ-1:0]   irq_en_o,
  output logic [NUM_FLAGS-1:0] stat_o
);
  timing_t              timing_q;
  logic [REG_DW-1:0]    div_q, sil_q;
  logic [NUM_IRQ-1:0]   en_q;
  logic [NUM_FLAGS-1:0] stat_q, stat_clr;

  assign soft_rst_o = wr_i && (addr_i == ADDR_CTRL) && wdata_i[0];
  assign pop_o      = rd_i && (addr_i == ADDR_RXDATA) && !fifo_empty_i;
  assign stat_clr   = (wr_i && (addr_i == ADDR_STAT)) ? wdata_i[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      timing_q <= '{min_code: 3'd7, ext_code: 3'd0};
      div_q    <= '0;
      sil_q    <= REG_DW'(SIL_RST);
      en_q     <= '0;
      stat_q   <= '0;
    end else begin
      // set wins over a clear in the same cycle
      stat_q <= (stat_q & ~stat_clr) | flag_set_i;
      if (wr_i) begin
        case (addr_i)
          ADDR_IRQ_EN:  en_q     <= wdata_i[NUM_IRQ-1:0];
          ADDR_TIMING:  timing_q <= wdata_i[REG_DW-1 -: 6];
          ADDR_DIV:     div_q    <= wdata_i;
          ADDR_SILENCE: sil_q    <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL:    rdata_o[1] = listen_i;
      ADDR_IRQ_EN:  rdata_o[NUM_IRQ-1:0] = en_q;
      ADDR_STAT:    rdata_o[NUM_FLAGS-1:0] = stat_q;
      ADDR_TIMING:  rdata_o[REG_DW-1 -: 6] = timing_q;
      ADDR_DIV:     rdata_o = div_q;
      ADDR_SILENCE: rdata_o = sil_q;
      ADDR_RXDATA:  rdata_o = fifo_empty_i ? '0 : fifo_dout_i;
      ADDR_RXCNT:   rdata_o = REG_DW'(fifo_cnt_i);
      default:      rdata_o = '0;
    endcase
  end

  // overflow flag sits above the enable range and cannot reach irq
  assign irq_o     = |(stat_q[NUM_IRQ-1:0] & en_q);
  assign timing_o  = timing_q;
  assign div_o     = div_q;
  assign sil_lim_o = sil_q;
  assign irq_en_o  = en_q;
  assign stat_o    = stat_q;
endmodule

// File: rtl/tone_reply_rx.sv
module tone_reply_rx
  import tone_rx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned REG_DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tone_i,
  input  logic              tx_start_i,
  input  logic              tx_done_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned CW = $clog2(FIFO_DEPTH) + 1;

  logic                 tick_w, listen_w, soft_rst_w, pop_w;
  logic                 byte_vld_w, done_w, err_w, norep_w;
  logic                 full_w, empty_w, push_w;
  logic [REG_DW-1:0]    byte_w, div_w, sil_w, fifo_dout_w;
  logic [CW-1:0]        fifo_cnt_w;
  timing_t              timing_w;
  logic [NUM_IRQ-1:0]   irq_en_w;
  logic [NUM_FLAGS-1:0] stat_w, flag_set_w;

  assign push_w = byte_vld_w & ~full_w;

  always_comb begin
    flag_set_w            = '0;
    flag_set_w[FLG_BYTE]  = push_w;
    flag_set_w[FLG_DONE]  = done_w;
    flag_set_w[FLG_ERR]   = err_w;
    flag_set_w[FLG_NOREP] = norep_w;
    flag_set_w[FLG_OVF]   = byte_vld_w & full_w;
  end

  tone_rx_tick #(.DIV_W(REG_DW)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .div_i  (div_w),
    .tick_o (tick_w)
  );

  tone_rx_decoder #(.CNT_W(REG_DW), .DATA_W(REG_DW)) i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_w),
    .tone_i     (tone_i),
    .tx_start_i (tx_start_i),
    .tx_done_i  (tx_done_i),
    .soft_rst_i (soft_rst_w),
    .timing_i   (timing_w),
    .sil_lim_i  (sil_w),
    .listen_o   (listen_w),
    .byte_vld_o (byte_vld_w),
    .byte_o     (byte_w),
    .done_o     (done_w),
    .err_o      (err_w),
    .norep_o    (norep_w)
  );

  tone_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(REG_DW)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_w),
    .din_i   (byte_w),
    .pop_i   (pop_w),
    .dout_o  (fifo_dout_w),
    .cnt_o   (fifo_cnt_w),
    .full_o  (full_w),
    .empty_o (empty_w)
  );

  tone_rx_regs #(.REG_DW(REG_DW), .CW(CW)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (reg_wr_i),
    .rd_i         (reg_rd_i),
    .addr_i       (reg_addr_i),
    .wdata_i      (reg_wdata_i),
    .listen_i     (listen_w),
    .flag_set_i   (flag_set_w),
    .fifo_dout_i  (fifo_dout_w),
    .fifo_cnt_i   (fifo_cnt_w),
    .fifo_empty_i (empty_w),
    .rdata_o      (reg_rdata_o),
    .irq_o        (irq_o),
    .soft_rst_o   (soft_rst_w),
    .pop_o        (pop_w),
    .timing_o     (timing_w),
    .div_o        (div_w),
    .sil_lim_o    (sil_w),
    .irq_en_o     (irq_en_w),
    .stat_o       (stat_w)
  );
endmodule

// File: rtl/tone_reply_rx_chk.sv
module tone_reply_rx_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_start_i,
  input logic          tx_done_i,
  input logic          irq_o,
  input logic          listen,
  input logic          soft_rst,
  input logic          byte_vld,
  input logic [3:0]    irq_en,
  input logic [4:0]    stat,
  input logic [CW-1:0] fifo_cnt
);
  // R8
  soft_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> !listen);

  // R9
  tx_start_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_i |=> !listen);

  // R6
  window_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_done_i && !tx_start_i && !soft_rst) |=> listen);

  // R11
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat[3:0] & irq_en) == 4'b0) |-> !irq_o);

  // R12
  fifo_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CW'(DEPTH));

  // R12
  overflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && fifo_cnt == CW'(DEPTH)) |=> stat[4]);
endmodule

bind tone_reply_rx tone_reply_rx_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_start_i (tx_start_i),
  .tx_done_i  (tx_done_i),
  .irq_o      (irq_o),
  .listen     (listen_w),
  .soft_rst   (soft_rst_w),
  .byte_vld   (byte_vld_w),
  .irq_en     (irq_en_w),
  .stat       (stat_w),
  .fifo_cnt   (fifo_cnt_w)
);

// File: tb/test_tone_reply_rx.sv
`timescale 1ns/1ps
module test_tone_reply_rx;
  localparam logic [2:0] A_CTRL = 3'd0, A_EN = 3'd1, A_STAT = 3'd2, A_TIM = 3'd3;
  localparam logic [2:0] A_DIV = 3'd4, A_SIL = 3'd5, A_DATA = 3'd6, A_CNT = 3'd7;
  localparam int SIL = 40;
  localparam int GAP = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       tone = 1'b0, tx_start = 1'b0, tx_done = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  int scale = 1;
  int w1 = 27, w0 = 35, wg = 20;
  logic [7:0] exp_q[$];
  logic [7:0] rv;

  always #4 clk = ~clk;

  tone_reply_rx i_tone_reply_rx (
    .clk_i(clk), .rst_ni(rst_n), .tone_i(tone), .tx_start_i(tx_start),
    .tx_done_i(tx_done), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd),
    .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, input logic pop);
    @(negedge clk); reg_addr = a; reg_rd = pop;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
  endtask

  task automatic burst(input int ticks);
    @(negedge clk); tone = 1'b1;
    repeat (ticks * scale) @(negedge clk);
    tone = 1'b0;
    repeat (GAP * scale) @(negedge clk);
  endtask

  task automatic send_bits(input logic [7:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) burst(d[i] ? w1 : w0);
  endtask

  // driver: pushes the expected byte into the scoreboard when it should be kept
  task automatic send_byte(input logic [7:0] d, input bit keep);
    send_bits(d, 8);
    if (keep) exp_q.push_back(d);
  endtask

  task automatic wait_close();
    repeat ((SIL + 6) * scale) @(negedge clk);
  endtask

  // monitor: pops scoreboard entries against bytes read from the design
  task automatic drain(input string req);
    logic [7:0] cnt, d;
    rd(A_CNT, cnt, 1'b0);
    check({req, " R13 count"}, cnt, 8'(exp_q.size()));
    while (exp_q.size() > 0) begin
      rd(A_DATA, d, 1'b1);
      check({req, " data"}, d, exp_q.pop_front());
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_TIM, rv, 1'b0);  check("R1 timing", rv, 8'hE0);
    rd(A_DIV, rv, 1'b0);  check("R1 div", rv, 8'h00);
    rd(A_SIL, rv, 1'b0);  check("R1 silence", rv, 8'd64);
    rd(A_EN, rv, 1'b0);   check("R1 irq_en", rv, 8'h00);
    rd(A_STAT, rv, 1'b0); check("R1 stat", rv, 8'h00);
    rd(A_CTRL, rv, 1'b0); check("R1 listening", rv, 8'h00);
    rd(A_CNT, rv, 1'b0);  check("R1 count", rv, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // min 24, extension 8 -> long threshold 32
    wr(A_TIM, 8'h04);
    wr(A_SIL, 8'(SIL));

    // R6 closed window ignores bursts
    send_byte(8'hA5, 1'b0);
    rd(A_CNT, rv, 1'b0);  check("R6 closed count", rv, 8'h00);
    rd(A_STAT, rv, 1'b0); check("R6 closed stat", rv, 8'h00);
    pulse_done();
    rd(A_CTRL, rv, 1'b0); check("R6 listening", rv, 8'h02);

    // R3 R4 R5 byte with glitches mixed in
    send_bits(8'hA5 >> 4, 4);
    burst(wg); burst(wg);
    send_bits(8'h05, 4);
    exp_q.push_back(8'hA5);
    wait_close();
    rd(A_STAT, rv, 1'b0); check("R5 R7 stat byte+done", rv, 8'h03);
    rd(A_CTRL, rv, 1'b0); check("R7 window closed", rv, 8'h00);
    drain("R3 R4 R5");

    // R11 R10
    wr(A_EN, 8'h02);
    check("R11 irq on", {7'b0, irq}, 8'h01);
    wr(A_STAT, 8'h02);
    rd(A_STAT, rv, 1'b0); check("R10 w1c keeps others", rv, 8'h01);
    check("R11 irq off", {7'b0, irq}, 8'h00);
    wr(A_STAT, 8'h00);
    rd(A_STAT, rv, 1'b0); check("R10 write 0 no effect", rv, 8'h01);
    wr(A_STAT, 8'h1F);

    // R7 no reply
    pulse_done();
    wait_close();
    rd(A_STAT, rv, 1'b0); check("R7 no reply", rv, 8'h08);
    wr(A_STAT, 8'h1F);

    // R3 only glitches -> still no reply
    pulse_done();
    for (int i = 0; i < 6; i++) burst(wg);
    wait_close();
    rd(A_STAT, rv, 1'b0); check("R3 glitches only", rv, 8'h08);
    wr(A_STAT, 8'h1F);

    // R7 partial byte
    pulse_done();
    send_bits(8'h05, 3);
    wait_close();
    rd(A_STAT, rv, 1'b0); check("R7 partial", rv, 8'h06);
    rd(A_CNT, rv, 1'b0);  check("R7 partial count", rv, 8'h00);
    wr(A_STAT, 8'h1F);

    // R8 soft abort
    pulse_done();
    send_bits(8'h0F, 4);
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, rv, 1'b0); check("R8 aborted", rv, 8'h00);
    send_byte(8'hFF, 1'b0);
    rd(A_CNT, rv, 1'b0);  check("R8 ignored count", rv, 8'h00);
    rd(A_STAT, rv, 1'b0); check("R8 ignored stat", rv, 8'h00);
    pulse_done();
    send_byte(8'h3C, 1'b1);
    wait_close();
    drain("R8");
    wr(A_STAT, 8'h1F);

    // R9 host start aborts
    pulse_done();
    send_bits(8'h15, 5);
    @(negedge clk); tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    rd(A_CTRL, rv, 1'b0); check("R9 aborted", rv, 8'h00);
    send_byte(8'h81, 1'b0);
    rd(A_CNT, rv, 1'b0);  check("R9 ignored count", rv, 8'h00);
    pulse_done();
    send_byte(8'h5A, 1'b1);
    wait_close();
    drain("R9");
    wr(A_STAT, 8'h1F);

    // R4 reserved extension code 7 acts as 11 -> long threshold 35
    wr(A_TIM, 8'h1C);
    w0 = 36;
    pulse_done();
    send_byte(8'h0F, 1'b1);
    wait_close();
    drain("R4 reserved ext");
    wr(A_TIM, 8'h04);
    w0 = 35;
    wr(A_STAT, 8'h1F);

    // R12 overflow, irq only on B2
    wr(A_EN, 8'h04);
    pulse_done();
    for (int i = 0; i < 9; i++) send_byte(8'(8'h11 * (i + 1)), i < 8);
    wait_close();
    rd(A_STAT, rv, 1'b0); check("R12 stat ovf", rv, 8'h13);
    check("R12 irq unaffected", {7'b0, irq}, 8'h00);
    drain("R12");
    rd(A_DATA, rv, 1'b1); check("R13 empty read", rv, 8'h00);
    rd(A_CNT, rv, 1'b0);  check("R13 empty count", rv, 8'h00);
    wr(A_STAT, 8'h1F);
    rd(A_STAT, rv, 1'b0); check("R10 all cleared", rv, 8'h00);

    // R2 divider 3 -> one tick per 4 clocks
    wr(A_DIV, 8'h03);
    scale = 4;
    pulse_done();
    send_byte(8'hC3, 1'b1);
    wait_close();
    rd(A_STAT, rv, 1'b0); check("R2 stat", rv, 8'h03);
    drain("R2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule